// File: doc/BRIEF.md
# Saturating Arithmetic and Clamp Unit

This block is a small integer datapath for signal-processing code. It adds and subtracts 32-bit operands with saturation, in signed or unsigned form. It also provides a wrapping signed add that only reports overflow. It can clamp a value into a range chosen at run time, given by a 5-bit position operand. The clamp comes in signed and unsigned forms, each with a full-word variant and a packed variant that treats the word as two independent 16-bit lanes.

The unit also keeps a sticky saturation flag. Every saturating or overflowing operation sets it, and it stays set until software pulses a dedicated clear input. An operation is presented with `opValid` high for one cycle. Its result is registered and appears on `result` after the next rising clock edge, with `resValid` high for that cycle. The flag updates at the same edge. Other condition flags are not produced.

Top module: `satclamp_unit`

## Requirements
- R1: Opcode 0 (signed add): when both operands share a sign bit and the sum's sign bit differs from `opA`, the result is 0x7FFFFFFF if `opA` is non-negative or 0x80000000 if it is negative, and the flag is set. Otherwise the result is the plain sum.
- R2: Opcode 1 (signed subtract, `opA - opB`): overflow exists when the operand sign bits differ and the difference's sign bit differs from `opA`. It then saturates as in R1 and sets the flag; otherwise the result is the plain difference.
- R3: Opcode 2 (unsigned add) gives 0xFFFFFFFF on a carry out. Opcode 3 (unsigned subtract) gives 0 on a borrow. Both set the flag when they saturate; otherwise they return the plain sum or difference.
- R4: Opcode 4 (wrapping signed add) always returns the 32-bit sum modulo 2^32. It sets the flag under the signed-add overflow condition of R1.
- R5: Opcode 5 (signed clamp) with position s in `satPos` limits `opA`, read as signed, to [-(2^s), 2^s - 1]. A value above the range gives 2^s - 1, and a value below it gives -(2^s); either case sets the flag. With s = 0 the range is {-1, 0}.
- R6: Opcode 6 (unsigned clamp) with position s returns 0 for a negative `opA` and 2^s - 1 for a value above 2^s - 1, setting the flag in both cases. Otherwise it returns `opA` unchanged.
- R7: Opcodes 7 (signed) and 8 (unsigned) apply the R5 or R6 clamp to each 16-bit half of `opA`, sign-extended. Each half is clamped on its own, and the low 16 bits of each clamp go back into the same half. The flag is set if either half saturates.
- R8: The flag is sticky. It falls only when `stickyClr` is high and no saturating operation is issued in that cycle. A saturation in the same cycle as `stickyClr` leaves it set.
- R9: After reset, `result`, `satFlag` and `resValid` are 0. `result` and `resValid` update one clock edge after `opValid`, and `result` holds its value while `opValid` is low.
- R10: Opcodes 9 to 15 give a result of 0 and leave the flag unchanged. `opB` plays no part in the clamp opcodes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Issues an operation this cycle |
| opCode | input | 4 | Operation select (see R1 to R10) |
| opA | input | 32 | First operand, or value to clamp |
| opB | input | 32 | Second operand for add and subtract |
| satPos | input | 5 | Clamp position s |
| stickyClr | input | 1 | Clears the sticky saturation flag |
| result | output | 32 | Registered result |
| resValid | output | 1 | High the cycle after an issued operation |
| satFlag | output | 1 | Sticky saturation flag |

## Verification
Two situations are hard to reach from the ports. The first is a clear that meets a saturating operation in the same cycle. The bench reaches it by first setting the flag, then issuing an overflowing add with `stickyClr` raised in that one cycle, and then checking that the flag stays high. The second is a packed clamp where only one lane saturates. The bench builds operands with one half far out of range and the other inside it, including the exact lower bound -(2^s), so that a flag or lane leaking from one half into the other shows up in the packed result.

// File: rtl/satclamp_pkg.sv
package satclamp_pkg;

  typedef enum logic [3:0] {
    OP_SADD    = 4'd0,
    OP_SSUB    = 4'd1,
    OP_UADD    = 4'd2,
    OP_USUB    = 4'd3,
    OP_WADD    = 4'd4,
    OP_SCLAMP  = 4'd5,
    OP_UCLAMP  = 4'd6,
    OP_SCLAMP2 = 4'd7,
    OP_UCLAMP2 = 4'd8
  } opcode_e;

  // strobes from decode to datapath
  typedef struct packed {
    logic arith;       // add or subtract path
    logic subtract;    // subtract instead of add
    logic signedOp;    // signed overflow rules
    logic saturate;    // replace result on overflow
    logic clamp;       // range clamp path
    logic clampSigned; // signed clamp range
    logic dual;        // per-lane clamp
  } strobe_t;

endpackage

// File: rtl/clamp_core.sv
module clamp_core #(
  parameter int W     = 32,
  parameter int POS_W = 5
) (
  input  logic [W-1:0]     val,
  input  logic [POS_W-1:0] pos,
  input  logic             signedMode,
  output logic [W-1:0]     res,
  output logic             hit
);
  logic [W-1:0] mask;
  logic [W-1:0] top;

  assign mask = (W'(1) << pos) - W'(1);
  assign top  = W'($signed(val) >>> pos);

  always_comb begin
    res = val;
    hit = 1'b0;
    if (signedMode) begin
      if (!top[W-1] && (top != '0)) begin
        res = mask;
        hit = 1'b1;
      end else if (top[W-1] && (top != '1)) begin
        res = ~mask;
        hit = 1'b1;
      end
    end else begin
      if (val[W-1]) begin
        res = '0;
        hit = 1'b1;
      end else if (val > mask) begin
        res = mask;
        hit = 1'b1;
      end
    end
  end
endmodule

// File: rtl/satclamp_ctrl.sv
module satclamp_ctrl
  import satclamp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [3:0] opCode,
  input  logic       stickyClr,
  input  logic       satEvent,
  output strobe_t    strb,
  output logic       satFlag,
  output logic       resValid
);
  always_comb begin
    strb = '0;
    case (opcode_e'(opCode))
      OP_SADD:    begin strb.arith = 1'b1; strb.signedOp = 1'b1; strb.saturate = 1'b1; end
      OP_SSUB:    begin strb.arith = 1'b1; strb.signedOp = 1'b1; strb.saturate = 1'b1; strb.subtract = 1'b1; end
      OP_UADD:    begin strb.arith = 1'b1; strb.saturate = 1'b1; end
      OP_USUB:    begin strb.arith = 1'b1; strb.saturate = 1'b1; strb.subtract = 1'b1; end
      OP_WADD:    begin strb.arith = 1'b1; strb.signedOp = 1'b1; end
      OP_SCLAMP:  begin strb.clamp = 1'b1; strb.clampSigned = 1'b1; end
      OP_UCLAMP:  begin strb.clamp = 1'b1; end
      OP_SCLAMP2: begin strb.clamp = 1'b1; strb.clampSigned = 1'b1; strb.dual = 1'b1; end
      OP_UCLAMP2: begin strb.clamp = 1'b1; strb.dual = 1'b1; end
      default:    strb = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      satFlag  <= 1'b0;
      resValid <= 1'b0;
    end else begin
      resValid <= opValid;
      if (satEvent)       satFlag <= 1'b1;
      else if (stickyClr) satFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/satclamp_dp.sv
module satclamp_dp
  import satclamp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 16,
  parameter int POS_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [POS_W-1:0]  satPos,
  output logic [DATA_W-1:0] result,
  output logic              satEvent
);
  localparam int LANES = DATA_W / LANE_W;
  localparam int MSB   = DATA_W - 1;
  localparam logic [DATA_W-1:0] S_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] S_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W:0]   sumW, diffW;
  logic              addOvf, subOvf, carryOut;
  logic [DATA_W-1:0] rawRes, arithRes;
  logic              arithHit;

  assign sumW   = {1'b0, opA} + {1'b0, opB};
  assign diffW  = {1'b0, opA} - {1'b0, opB};
  assign addOvf = (opA[MSB] == opB[MSB]) && (sumW[MSB] != opA[MSB]);
  assign subOvf = (opA[MSB] != opB[MSB]) && (diffW[MSB] != opA[MSB]);

  always_comb begin
    rawRes   = strb.subtract ? diffW[DATA_W-1:0] : sumW[DATA_W-1:0];
    arithRes = rawRes;
    arithHit = 1'b0;
    carryOut = strb.subtract ? diffW[DATA_W] : sumW[DATA_W];
    if (strb.signedOp) begin
      arithHit = strb.subtract ? subOvf : addOvf;
      if (arithHit && strb.saturate)
        arithRes = opA[MSB] ? S_MIN : S_MAX;
    end else begin
      arithHit = carryOut;
      if (carryOut)
        arithRes = strb.subtract ? '0 : '1;
    end
  end

  // full-width clamp
  logic [DATA_W-1:0] fullRes;
  logic              fullHit;

  clamp_core #(.W(DATA_W), .POS_W(POS_W)) u_full (
    .val(opA), .pos(satPos), .signedMode(strb.clampSigned),
    .res(fullRes), .hit(fullHit)
  );

  // per-lane clamps
  logic [LANES-1:0][LANE_W-1:0] dualRes;
  logic [LANES-1:0]             dualHit;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DATA_W-1:0] laneIn, laneOut;
    assign laneIn = {{(DATA_W-LANE_W){opA[g*LANE_W+LANE_W-1]}}, opA[g*LANE_W +: LANE_W]};
    clamp_core #(.W(DATA_W), .POS_W(POS_W)) u_lane (
      .val(laneIn), .pos(satPos), .signedMode(strb.clampSigned),
      .res(laneOut), .hit(dualHit[g])
    );
    assign dualRes[g] = laneOut[LANE_W-1:0];
  end

  logic [DATA_W-1:0] nextRes;
  logic              nextHit;

  always_comb begin
    nextRes = '0;
    nextHit = 1'b0;
    if (strb.clamp) begin
      nextRes = strb.dual ? DATA_W'(dualRes) : fullRes;
      nextHit = strb.dual ? (|dualHit) : fullHit;
    end else if (strb.arith) begin
      nextRes = arithRes;
      nextHit = arithHit;
    end
  end

  assign satEvent = opValid && nextHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        result <= '0;
    else if (opValid) result <= nextRes;
  end
endmodule

// File: rtl/satclamp_unit.sv
module satclamp_unit
  import satclamp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 16,
  parameter int POS_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [3:0]        opCode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [POS_W-1:0]  satPos,
  input  logic              stickyClr,
  output logic [DATA_W-1:0] result,
  output logic              resValid,
  output logic              satFlag
);
  strobe_t strb;
  logic    satEvent;

  satclamp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .stickyClr(stickyClr), .satEvent(satEvent), .strb(strb),
    .satFlag(satFlag), .resValid(resValid)
  );

  satclamp_dp #(.DATA_W(DATA_W), .LANE_W(LANE_W), .POS_W(POS_W)) u_dp (
    .clk(clk), .rstN(rstN), .opValid(opValid), .strb(strb),
    .opA(opA), .opB(opB), .satPos(satPos),
    .result(result), .satEvent(satEvent)
  );
endmodule

// File: rtl/satclamp_chk.sv
module satclamp_chk #(
  parameter int DATA_W = 32,
  parameter int POS_W  = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [3:0]        opCode,
  input logic [DATA_W-1:0] opA,
  input logic [POS_W-1:0]  satPos,
  input logic              stickyClr,
  input logic [DATA_W-1:0] result,
  input logic              resValid,
  input logic              satFlag
);
  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (satFlag && !stickyClr) |=> satFlag);
  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stickyClr && !opValid) |=> !satFlag);
  // R9
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> resValid);
  // R9
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> (!resValid && $stable(result)));
  // R3
  uadd_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 4'd2) |=> (result >= $past(opA)));
  // R3
  usub_ceiling_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 4'd3) |=> (result <= $past(opA)));
  // R5
  spos_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 4'd5 && satPos == '0) |=> (result == '0 || result == '1));
  // R10
  unknown_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode > 4'd8) |=> (result == '0 && satFlag == $past(satFlag)));
endmodule

bind satclamp_unit satclamp_chk #(.DATA_W(DATA_W), .POS_W(POS_W)) u_chk (
  .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .opA(opA),
  .satPos(satPos), .stickyClr(stickyClr), .result(result),
  .resValid(resValid), .satFlag(satFlag)
);

// File: tb/sim_satclamp_unit.sv
module sim_satclamp_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [3:0]  opCode = '0;
  logic [31:0] opA = '0, opB = '0;
  logic [4:0]  satPos = '0;
  logic        stickyClr = 1'b0;
  logic [31:0] result;
  logic        resValid, satFlag;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  satclamp_unit u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .opA(opA), .opB(opB), .satPos(satPos), .stickyClr(stickyClr),
    .result(result), .resValid(resValid), .satFlag(satFlag)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clearFlag();
    @(negedge clk) stickyClr = 1'b1;
    @(negedge clk) stickyClr = 1'b0;
  endtask

  // issue one op, sample at the following negedge
  task automatic issue(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] pos, input logic clr);
    @(negedge clk);
    opValid = 1'b1; opCode = op; opA = a; opB = b; satPos = pos; stickyClr = clr;
    @(negedge clk);
    opValid = 1'b0; stickyClr = 1'b0;
  endtask

  task automatic runOp(input string tag, input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [4:0] pos,
                       input logic [31:0] expRes, input logic expFlag);
    clearFlag();
    issue(op, a, b, pos, 1'b0);
    check({tag, " result"}, result, expRes);
    check({tag, " flag"}, {31'b0, satFlag}, {31'b0, expFlag});
  endtask

  task automatic testReset();
    check("R9 reset result", result, 32'h0);
    check("R9 reset flag", {31'b0, satFlag}, 32'h0);
    check("R9 reset valid", {31'b0, resValid}, 32'h0);
  endtask

  task automatic testSignedAdd();
    runOp("R1 max+1", 4'd0, 32'h7FFFFFFF, 32'h1, 5'd0, 32'h7FFFFFFF, 1'b1);
    runOp("R1 min-1", 4'd0, 32'h80000000, 32'hFFFFFFFF, 5'd0, 32'h80000000, 1'b1);
    runOp("R1 plain", 4'd0, 32'd5, 32'hFFFFFFFD, 5'd0, 32'd2, 1'b0);
  endtask

  task automatic testSignedSub();
    runOp("R2 min-1", 4'd1, 32'h80000000, 32'h1, 5'd0, 32'h80000000, 1'b1);
    runOp("R2 max+1", 4'd1, 32'h7FFFFFFF, 32'hFFFFFFFF, 5'd0, 32'h7FFFFFFF, 1'b1);
    runOp("R2 plain", 4'd1, 32'd10, 32'd3, 5'd0, 32'd7, 1'b0);
  endtask

  task automatic testUnsigned();
    runOp("R3 uadd carry", 4'd2, 32'hFFFFFFF0, 32'h20, 5'd0, 32'hFFFFFFFF, 1'b1);
    runOp("R3 uadd plain", 4'd2, 32'd1, 32'd2, 5'd0, 32'd3, 1'b0);
    runOp("R3 usub borrow", 4'd3, 32'd3, 32'd5, 5'd0, 32'd0, 1'b1);
    runOp("R3 usub plain", 4'd3, 32'd5, 32'd3, 5'd0, 32'd2, 1'b0);
  endtask

  task automatic testWrapAdd();
    runOp("R4 wrap ovf", 4'd4, 32'h7FFFFFFF, 32'h1, 5'd0, 32'h80000000, 1'b1);
    runOp("R4 wrap plain", 4'd4, 32'd1, 32'd1, 5'd0, 32'd2, 1'b0);
  endtask

  task automatic testSignedClamp();
    runOp("R5 high", 4'd5, 32'd300, 32'hDEAD, 5'd7, 32'h7F, 1'b1);
    runOp("R5 low", 4'd5, 32'hFFFFFED4, 32'h0, 5'd7, 32'hFFFFFF80, 1'b1);
    runOp("R5 inside", 4'd5, 32'd100, 32'h0, 5'd7, 32'd100, 1'b0);
    runOp("R5 lower bound", 4'd5, 32'hFFFFFF80, 32'h0, 5'd7, 32'hFFFFFF80, 1'b0);
    runOp("R5 pos0 high", 4'd5, 32'd5, 32'h0, 5'd0, 32'h0, 1'b1);
    runOp("R5 pos0 minus1", 4'd5, 32'hFFFFFFFF, 32'h0, 5'd0, 32'hFFFFFFFF, 1'b0);
    runOp("R5 pos0 low", 4'd5, 32'hFFFFFFF9, 32'h0, 5'd0, 32'hFFFFFFFF, 1'b1);
  endtask

  task automatic testUnsignedClamp();
    runOp("R6 negative", 4'd6, 32'hFFFFFFFB, 32'h0, 5'd8, 32'h0, 1'b1);
    runOp("R6 above", 4'd6, 32'd300, 32'h0, 5'd8, 32'd255, 1'b1);
    runOp("R6 at max", 4'd6, 32'd255, 32'h0, 5'd8, 32'd255, 1'b0);
  endtask

  task automatic testDual();
    runOp("R7 s both", 4'd7, 32'h0100FF00, 32'h0, 5'd7, 32'h007FFF80, 1'b1);
    runOp("R7 s low only", 4'd7, 32'h00058000, 32'h0, 5'd7, 32'h0005FF80, 1'b1);
    runOp("R7 s inside", 4'd7, 32'h0010FF80, 32'h0, 5'd7, 32'h0010FF80, 1'b0);
    runOp("R7 u mixed", 4'd8, 32'hFFFF0123, 32'h0, 5'd8, 32'h000000FF, 1'b1);
  endtask

  task automatic testSticky();
    clearFlag();
    issue(4'd0, 32'h7FFFFFFF, 32'h1, 5'd0, 1'b0);
    issue(4'd0, 32'd1, 32'd1, 5'd0, 1'b0);
    check("R8 sticky after plain op", {31'b0, satFlag}, 32'h1);
    issue(4'd0, 32'h7FFFFFFF, 32'h1, 5'd0, 1'b1);
    check("R8 set beats clear", {31'b0, satFlag}, 32'h1);
    clearFlag();
    check("R8 clear", {31'b0, satFlag}, 32'h0);
  endtask

  task automatic testHoldAndUnknown();
    clearFlag();
    issue(4'd2, 32'd40, 32'd2, 5'd0, 1'b0);
    check("R9 valid after op", {31'b0, resValid}, 32'h1);
    @(negedge clk);
    @(negedge clk);
    check("R9 hold result", result, 32'd42);
    check("R9 valid idle", {31'b0, resValid}, 32'h0);
    issue(4'd15, 32'h7FFFFFFF, 32'h1, 5'd3, 1'b0);
    check("R10 unknown result", result, 32'h0);
    check("R10 unknown flag low", {31'b0, satFlag}, 32'h0);
    issue(4'd0, 32'h7FFFFFFF, 32'h1, 5'd0, 1'b0);
    issue(4'd9, 32'h0, 32'h0, 5'd0, 1'b0);
    check("R10 unknown flag kept", {31'b0, satFlag}, 32'h1);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    #1;
    testReset();
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    testSignedAdd();
    testSignedSub();
    testUnsigned();
    testWrapAdd();
    testSignedClamp();
    testUnsignedClamp();
    testDual();
    testSticky();
    testHoldAndUnknown();
    finishRun();
  end
endmodule